// File: doc/BRIEF.md
# Per-Node Stuck-At Fault Injector

This block wraps a small combinational circuit and puts a fault-injection point on each of its nets. The circuit is a 2-input NAND of inputs A and B whose result, together with input C, feeds a 2-input OR that forms the output. Each net is cut. A two-stage multiplexer is placed in the cut: the first stage picks the normal value or a forced value, and the second stage picks whether the forced value is low or high. All five nets get this treatment: the three inputs, the internal NAND-to-OR net and the output.

A global enable turns injection on. A node index chooses which single net is faulted, and a polarity bit chooses stuck-at-0 or stuck-at-1. Each fault therefore has a number equal to the node index times two plus the polarity, which gives ten faults. A test flow applies input vectors with one fault active at a time. It compares the output against the fault-free response to decide which vectors expose which faults.

Both outputs are registered for timing closure. A separate view shows the NAND driver before its own injection point, so an internal fault can be seen not to disturb its driver.

Top module: `stuck_fault_wrap`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `y_q` and `mid_q` are 0 after that edge.
- R2: Each output shows the state computed from the inputs sampled at the previous rising edge, with exactly one register stage of latency.
- R3: With `inj_en` low, `y_q` equals NOT(A AND B) OR C for all 8 input vectors, whatever `node_sel` and `stuck_one` hold.
- R4: Node codes on `node_sel` are 0=A, 1=B, 2=C, 3=internal NAND net, 4=output. `stuck_one`=0 forces the chosen net low and `stuck_one`=1 forces it high. An input-node fault makes every downstream gate see the forced level.
- R5: A fault on node 3 changes only what the OR gate sees. `mid_q` still shows NOT(A AND B) of the inputs, and `y_q` equals the forced level OR C.
- R6: A fault on node 4 makes `y_q` equal the forced level for every input vector.
- R7: Node codes 5 to 7 inject nothing, so the behaviour is the same as with `inj_en` low.
- R8: For each of the ten faults, at least one of the vectors ABC=010, 100, 110, 111 gives an output different from the fault-free value.
- R9: Vector 110 exposes A@0, B@0, C@1 and NAND-net@1. Vector 100 exposes B@1 and NAND-net@0. Vector 010 exposes A@1. Vector 111 exposes C@0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inj_en | input | 1 | Fault injection enable (1 = test mode) |
| stuck_one | input | 1 | Forced level: 0 stuck-at-0, 1 stuck-at-1 |
| node_sel | input | 3 | Index of the net to fault |
| in_a | input | 1 | Circuit input A |
| in_b | input | 1 | Circuit input B |
| in_c | input | 1 | Circuit input C |
| y_q | output | 1 | Registered, possibly faulty circuit output |
| mid_q | output | 1 | Registered NAND driver value, taken ahead of its injection point |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge once reset is released. They also assume that the control inputs may change on any cycle, because each property compares against the value sampled one edge earlier. The stimulus changes all inputs only on falling edges and never leaves them undriven. It steps through every fault number and every vector, the out-of-range node codes, and injection turned off with a live index. In each case the output is read one edge after the inputs change.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  localparam int unsigned NODES  = 5;
  localparam int unsigned SEL_W  = $clog2(NODES);
  localparam int unsigned N_IN   = 3;
  localparam int unsigned NODE_A = 0;
  localparam int unsigned NODE_B = 1;
  localparam int unsigned NODE_C = 2;
  localparam int unsigned NODE_N = 3;
  localparam int unsigned NODE_Y = 4;
endpackage

// File: rtl/sfw_fault_decode.sv
module sfw_fault_decode
  import sfw_pkg::*;
(
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [NODES-1:0] hit
);
  for (genvar k = 0; k < NODES; k++) begin : g_hit
    assign hit[k] = en && (sel == SEL_W'(k));
  end
endmodule

// File: rtl/sfw_stuck_mux.sv
module sfw_stuck_mux (
  input  logic d,
  input  logic hit,
  input  logic stuck_one,
  output logic q
);
  logic forced;
  // second stage: pick the stuck level
  assign forced = stuck_one ? 1'b1 : 1'b0;
  // first stage: normal data or fault
  assign q = hit ? forced : d;
endmodule

// File: rtl/stuck_fault_wrap.sv
module stuck_fault_wrap
  import sfw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inj_en,
  input  logic             stuck_one,
  input  logic [SEL_W-1:0] node_sel,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             in_c,
  output logic             y_q,
  output logic             mid_q
);
  logic [NODES-1:0] hit;
  logic [N_IN-1:0]  in_raw;
  logic [N_IN-1:0]  in_inj;
  logic             n_drv, n_inj, y_drv, y_inj;

  sfw_fault_decode u_dec (
    .en  (inj_en),
    .sel (node_sel),
    .hit (hit)
  );

  assign in_raw = {in_c, in_b, in_a};

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    sfw_stuck_mux u_mux (
      .d         (in_raw[i]),
      .hit       (hit[i]),
      .stuck_one (stuck_one),
      .q         (in_inj[i])
    );
  end

  assign n_drv = ~(in_inj[NODE_A] & in_inj[NODE_B]);

  sfw_stuck_mux u_mux_n (
    .d         (n_drv),
    .hit       (hit[NODE_N]),
    .stuck_one (stuck_one),
    .q         (n_inj)
  );

  assign y_drv = n_inj | in_inj[NODE_C];

  sfw_stuck_mux u_mux_y (
    .d         (y_drv),
    .hit       (hit[NODE_Y]),
    .stuck_one (stuck_one),
    .q         (y_inj)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q   <= 1'b0;
      mid_q <= 1'b0;
    end else begin
      y_q   <= y_inj;
      mid_q <= n_drv;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!y_q && !mid_q));

  a_r3_bypass_function: assert property (@(posedge clk) disable iff (rst)
    !inj_en |=> (y_q == $past(~(in_a & in_b) | in_c)));

  a_r5_driver_untouched: assert property (@(posedge clk) disable iff (rst)
    (inj_en && node_sel == SEL_W'(NODE_N)) |=> (mid_q == $past(~(in_a & in_b))));

  a_r6_output_forced: assert property (@(posedge clk) disable iff (rst)
    (inj_en && node_sel == SEL_W'(NODE_Y)) |=> (y_q == $past(stuck_one)));

  a_r7_out_of_range: assert property (@(posedge clk) disable iff (rst)
    (node_sel >= SEL_W'(NODES)) |=> (y_q == $past(~(in_a & in_b) | in_c)));
endmodule

// File: tb/stuck_fault_wrap_bench.sv
module stuck_fault_wrap_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inj_en = 1'b0, stuck_one = 1'b0;
  logic [2:0] node_sel = 3'd0;
  logic       in_a = 1'b0, in_b = 1'b0, in_c = 1'b0;
  logic       y_q, mid_q;
  int         checks = 0, errors = 0;

  // fault-free response, bit v = output for vector {A,B,C}
  localparam logic [7:0] GOOD = 8'hBF;
  // faulty responses by fault number = node*2 + polarity
  localparam logic [7:0] RESP [0:9] = '{8'hFF, 8'hBB, 8'hFF, 8'hAF, 8'h3F,
                                        8'hFF, 8'hAA, 8'hFF, 8'h00, 8'hFF};
  logic [7:0] obs [0:9];

  stuck_fault_wrap u_stuck_fault_wrap (
    .clk(clk), .rst(rst), .inj_en(inj_en), .stuck_one(stuck_one),
    .node_sel(node_sel), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .y_q(y_q), .mid_q(mid_q)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input logic en, input logic [2:0] nd, input logic pol,
                       input logic [2:0] v);
    @(negedge clk);
    inj_en = en; node_sel = nd; stuck_one = pol;
    {in_a, in_b, in_c} = v;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    {in_a, in_b, in_c} = 3'b111;
    @(negedge clk); @(negedge clk);
    check("R1 y_q", y_q, 1'b0);
    check("R1 mid_q", mid_q, 1'b0);
    rst = 1'b0;

    // R3: disabled, index live, all vectors
    for (int v = 0; v < 8; v++) begin
      apply(1'b0, 3'(v % 5), v[0], 3'(v));
      check("R3 bypass", y_q, GOOD[v]);
    end

    // R4 R5 R6: table walk over all faults and vectors
    for (int f = 0; f < 10; f++) begin
      for (int v = 0; v < 8; v++) begin
        apply(1'b1, 3'(f / 2), f[0], 3'(v));
        obs[f][v] = y_q;
        check(f < 6 ? "R4 input fault" : (f < 8 ? "R5 nand fault" : "R6 out fault"),
              y_q, RESP[f][v]);
        if (f == 6 || f == 7)
          check("R5 driver view", mid_q, ~(v[2] & v[1]));
      end
    end

    // R8: reduced vector set covers each fault
    for (int f = 0; f < 10; f++) begin
      logic det;
      det = (obs[f][2] != GOOD[2]) | (obs[f][4] != GOOD[4]) |
            (obs[f][6] != GOOD[6]) | (obs[f][7] != GOOD[7]);
      check("R8 coverage", det, 1'b1);
    end

    // R9: named detections
    check("R9 110 A@0", obs[0][6] != GOOD[6], 1'b1);
    check("R9 110 B@0", obs[2][6] != GOOD[6], 1'b1);
    check("R9 110 C@1", obs[5][6] != GOOD[6], 1'b1);
    check("R9 110 N@1", obs[7][6] != GOOD[6], 1'b1);
    check("R9 100 B@1", obs[3][4] != GOOD[4], 1'b1);
    check("R9 100 N@0", obs[6][4] != GOOD[4], 1'b1);
    check("R9 010 A@1", obs[1][2] != GOOD[2], 1'b1);
    check("R9 111 C@0", obs[4][7] != GOOD[7], 1'b1);

    // R7: node codes 5..7 inject nothing
    for (int n = 5; n < 8; n++) begin
      for (int v = 0; v < 8; v++) begin
        apply(1'b1, 3'(n), v[1], 3'(v));
        check("R7 idle code", y_q, GOOD[v]);
      end
    end

    // R2: one-cycle latency, output changes on the edge after input
    @(negedge clk);
    inj_en = 1'b0; {in_a, in_b, in_c} = 3'b110;
    @(negedge clk);
    check("R2 settled", y_q, 1'b0);
    in_c = 1'b1;
    #5;
    check("R2 held before edge", y_q, 1'b0);
    @(negedge clk);
    check("R2 after edge", y_q, 1'b1);

    // R1: reset mid-run clears state
    @(negedge clk);
    rst = 1'b1; {in_a, in_b, in_c} = 3'b001;
    @(negedge clk);
    check("R1 rerun y_q", y_q, 1'b0);
    check("R1 rerun mid_q", mid_q, 1'b0);
    rst = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule